// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that answers like a two-byte-addressed serial EEPROM. A 4096-byte on-chip RAM array stands in for the storage cells. A controller sets the internal pointer by writing two address bytes after the bus address. It then either sends data bytes to store or issues a repeated START and reads. Reads stream out from the pointer, one byte after another.

Written bytes are collected in a one-page buffer and copied into the array only when the STOP arrives. A busy window then opens, and during it the block ignores its own bus address. A page is 32 bytes, and the pointer wraps inside the current page while data bytes are being written. The bus address is a fixed four-bit class code followed by three strap inputs. The block only pulls SDA low; the open-drain wiring and pull-up sit outside it.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 1010 followed by `strap[2:0]` (bit 0 is the direction, 0 = write, 1 = read). Any other address is not acknowledged, and the block leaves SDA released until the next START.
- R2: In a write, the first byte after the address sets pointer bits 15..8 and the second sets bits 7..0. Pointer bits above bit 11 are discarded.
- R3: Data bytes after the two address bytes are stored from the pointer onward, but only at STOP. The low five pointer bits wrap within the 32-byte page, so the page never changes during a write.
- R4: After a STOP that ends a write carrying at least one data byte, the block does not acknowledge its address for BUSY_CYCLES system clocks. A write with no data bytes starts no busy window.
- R5: A random read consists of a write of the two address bytes, then a repeated START, then the address with the read bit. It returns the byte at that address, most significant bit first.
- R6: The pointer advances after every byte read. It wraps from 0xFFF to 0x000, so one read can stream the whole array.
- R7: After the controller NACKs a read byte, the block releases SDA and drives nothing until the next START or STOP. SDA is released after reset.
- R8: A START that arrives before the STOP discards the data bytes already received. Nothing is stored and no busy window follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| strap | input | 3 | Low three bits of the bus address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Two things can overlap in time: the background copy of the page buffer into the array, and a new transaction that starts on the bus during the busy window. The bench writes a page and, straight after the STOP, addresses the block again. It expects no acknowledge. After the window ends it reads the page back and compares it with the values it wrote, which shows that the copy was not disturbed by the bus traffic.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int MEM_BYTES   = 4096,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 2000,
  parameter logic [3:0] DEV_CLASS = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  output logic       sda_oe
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BUSY_LEN = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;
  localparam int BW = $clog2(BUSY_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_WR, S_RD, S_RACK} st_t;

  logic [1:0] scl_m, sda_m;
  logic scl_s, sda_s, scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic rw;
  logic [1:0] widx;
  logic [AW-1:0] ptr;
  logic [BW-1:0] busy_cnt;
  logic commit_on;
  logic [PW-1:0] cidx;
  logic [PAGE_BYTES-1:0] pmask;
  logic [7:0] pbuf [PAGE_BYTES];
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i}; sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s; sda_q <= sda_s;
    end

  assign scl_s = scl_m[1];
  assign sda_s = sda_m[1];

  wire start   = scl_s & scl_q & sda_q & ~sda_s;
  wire stop    = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;
  wire busy    = busy_cnt != '0;
  wire [7:0] rd_byte = mem[ptr];
  wire byte_in = fall && cnt == 4'd8;
  wire mem_we  = commit_on & pmask[cidx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; rw <= 1'b0; widx <= '0; ptr <= '0;
      busy_cnt <= '0; commit_on <= 1'b0; cidx <= '0; pmask <= '0; sda_oe <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - BW'(1);
      if (commit_on) begin
        pmask[cidx] <= 1'b0;
        cidx <= cidx + PW'(1);
        if (cidx == PW'(PAGE_BYTES - 1)) commit_on <= 1'b0;
      end
      if (start) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0; widx <= '0;
        if (!commit_on) pmask <= '0;
      end else if (stop) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        if (|pmask && !commit_on && !busy) begin
          busy_cnt <= BW'(BUSY_LEN); commit_on <= 1'b1; cidx <= '0;
        end
      end else begin
        case (st)
          S_ADDR:
            if (rise) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (byte_in) begin
              if (sh[7:1] == {DEV_CLASS, strap} && !busy) begin
                rw <= sh[0]; st <= S_ACK; sda_oe <= 1'b1;
              end else st <= S_IDLE;
            end
          S_ACK:
            if (fall) begin
              cnt <= '0;
              if (rw) begin
                st <= S_RD; sh <= rd_byte; sda_oe <= ~rd_byte[7];
              end else begin
                st <= S_WR; sda_oe <= 1'b0;
              end
            end
          S_WR:
            if (rise) begin
              sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1;
            end else if (byte_in) begin
              case (widx)
                2'd0:    ptr <= {sh[AW-9:0], 8'h00};
                2'd1:    ptr <= {ptr[AW-1:8], sh};
                default: begin
                  pmask[ptr[PW-1:0]] <= 1'b1;
                  ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                end
              endcase
              if (widx != 2'd2) widx <= widx + 2'd1;
              st <= S_ACK; sda_oe <= 1'b1;
            end
          S_RD:
            if (fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; st <= S_RACK; ptr <= ptr + AW'(1);
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
              end
            end
          S_RACK:
            if (rise && sda_s) st <= S_IDLE;
            else if (fall) begin
              st <= S_RD; cnt <= '0; sh <= rd_byte; sda_oe <= ~rd_byte[7];
            end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (st == S_WR && byte_in && widx == 2'd2 && !start && !stop)
      pbuf[ptr[PW-1:0]] <= sh;

  always_ff @(posedge clk)
    if (mem_we) mem[{ptr[AW-1:PW], cidx}] <= pbuf[cidx];

  p_no_write_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> st != S_WR);
  p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (widx == 2'd2 && $past(widx) == 2'd2) |-> $stable(ptr[AW-1:PW]));
  p_commit_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_on |-> busy);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);
  p_drive_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
  localparam int H = 10;
  localparam int BUSY = 400;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] AW_B = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] AR_B = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_low = 1'b0;
  logic sda_oe;
  wire sda_line = ~(sda_low | sda_oe);
  int checks = 0, errs = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap(STRAP), .sda_oe(sda_oe));

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      errs = errs + 1; checks = checks + 1;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wt(int n); repeat (n) @(posedge clk); endtask

  task automatic i_start();
    sda_low <= 1'b1; wt(H); scl <= 1'b0; wt(2);
  endtask
  task automatic i_rstart();
    sda_low <= 1'b0; wt(H); scl <= 1'b1; wt(H); sda_low <= 1'b1; wt(H); scl <= 1'b0; wt(2);
  endtask
  task automatic i_stop();
    sda_low <= 1'b1; wt(H); scl <= 1'b1; wt(H); sda_low <= 1'b0; wt(H);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_low <= ~b[i]; wt(H); scl <= 1'b1; wt(H); scl <= 1'b0; wt(2);
    end
    sda_low <= 1'b0; wt(H); scl <= 1'b1; wt(H/2); @(negedge clk);
    ack = ~sda_line; wt(H/2); scl <= 1'b0; wt(2);
  endtask

  task automatic recv_byte(logic ack_m, output logic [7:0] b);
    sda_low <= 1'b0;
    for (int i = 0; i < 8; i++) begin
      wt(H); scl <= 1'b1; wt(H/2); @(negedge clk);
      b = {b[6:0], sda_line}; wt(H/2); scl <= 1'b0; wt(2);
    end
    sda_low <= ack_m; wt(H); scl <= 1'b1; wt(H); scl <= 1'b0; wt(2); sda_low <= 1'b0;
  endtask

  task automatic wr(logic [15:0] a, int n, logic [31:0] d);
    logic ack;
    i_start();
    send_byte(AW_B, ack); chk("R1 write address ack", ack, 1);
    send_byte(a[15:8], ack); chk("R2 high byte ack", ack, 1);
    send_byte(a[7:0], ack); chk("R2 low byte ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[31-8*i -: 8], ack); chk("R3 data ack", ack, 1);
    end
    i_stop();
  endtask

  task automatic rd(logic [15:0] a, int n, output logic [31:0] q);
    logic ack; logic [7:0] b;
    q = '0;
    i_start();
    send_byte(AW_B, ack); chk("R5 address ack", ack, 1);
    send_byte(a[15:8], ack);
    send_byte(a[7:0], ack);
    i_rstart();
    send_byte(AR_B, ack); chk("R5 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b); q = {q[23:0], b};
    end
    i_stop();
  endtask

  task automatic probe(output logic ack);
    i_start(); send_byte(AW_B, ack); i_stop();
  endtask

  task automatic t_reset();
    @(negedge clk); chk("R7 SDA released after reset", sda_line, 1);
  endtask

  task automatic t_address();
    logic ack;
    i_start(); send_byte({4'b1010, 3'b001, 1'b0}, ack); i_stop();
    chk("R1 wrong strap not acked", ack, 0);
    i_start(); send_byte(AW_B, ack); chk("R1 own address acked", ack, 1);
    send_byte(8'h00, ack); send_byte(8'h10, ack); i_stop();
    probe(ack); chk("R4 no busy after address-only write", ack, 1);
  endtask

  task automatic t_write_busy();
    logic ack; logic [31:0] q;
    wr(16'hF123, 4, 32'hA0A1A2A3);
    probe(ack); chk("R4 address ignored while busy", ack, 0);
    wt(BUSY + 50);
    probe(ack); chk("R4 acked after busy window", ack, 1);
    rd(16'h0123, 4, q); chk("R2 R6 sequential read, upper bits dropped", q, 32'hA0A1A2A3);
    rd(16'h0125, 1, q); chk("R5 random read single byte", q, 32'h000000A2);
  endtask

  task automatic t_page_wrap();
    logic [31:0] q;
    wr(16'h0040, 1, 32'h55000000); wt(BUSY + 50);
    wr(16'h003E, 4, 32'hB0B1B2B3); wt(BUSY + 50);
    rd(16'h003E, 2, q); chk("R3 bytes before page end", q, 32'h0000B0B1);
    rd(16'h0020, 2, q); chk("R3 wrapped to page start", q, 32'h0000B2B3);
    rd(16'h0040, 1, q); chk("R3 next page untouched", q, 32'h00000055);
  endtask

  task automatic t_rollover();
    logic [31:0] q;
    wr(16'h0FFE, 2, 32'hE1E20000); wt(BUSY + 50);
    wr(16'h0000, 2, 32'h01020000); wt(BUSY + 50);
    rd(16'h0FFE, 4, q); chk("R6 pointer wraps 0xFFF to 0x000", q, 32'hE1E20102);
  endtask

  task automatic t_nack_release();
    logic ack; logic [7:0] b;
    i_start(); send_byte(AW_B, ack); send_byte(8'h01, ack); send_byte(8'h23, ack);
    i_rstart(); send_byte(AR_B, ack);
    recv_byte(1'b0, b); chk("R7 last byte before NACK", b, 8'hA0);
    recv_byte(1'b0, b); chk("R7 SDA released after NACK", b, 8'hFF);
    i_stop();
  endtask

  task automatic t_abort();
    logic ack; logic [7:0] b; logic [31:0] q;
    wr(16'h0200, 1, 32'h11000000); wt(BUSY + 50);
    i_start(); send_byte(AW_B, ack); send_byte(8'h02, ack); send_byte(8'h00, ack);
    send_byte(8'h77, ack);
    i_rstart(); send_byte(AR_B, ack); recv_byte(1'b0, b); i_stop();
    probe(ack); chk("R8 no busy after aborted write", ack, 1);
    rd(16'h0200, 1, q); chk("R8 aborted data not stored", q, 32'h00000011);
  endtask

  initial begin
    wt(5); rst_n <= 1'b1; wt(5);
    t_reset();
    t_address();
    t_write_busy();
    t_page_wrap();
    t_rollover();
    t_nack_release();
    t_abort();
    done = 1;
    report();
  end
endmodule